// File: doc/BRIEF.md
# Serial converter power-mode controller

This block is the digital front end of a 12-bit serial sampling converter. It watches an active-low chip-select and a serial clock, both sampled with a faster system clock, and counts the serial-clock falling edges in each frame. A frame opens when chip-select falls. The sample on the parallel input is captured at that point and then shifted out behind four leading zeros, with the MSB first.

The position of the chip-select rising edge, measured in serial-clock falling edges, sets the power mode. There is no command register. A very early release is ignored as a glitch. A release in the middle window puts the part to sleep. A late release keeps it awake and aborts the transfer. While the part is asleep, only a frame held low past the wake threshold brings it back up, and valid data comes from the frame after that one. A track flag follows the sample-and-hold state.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After the asynchronous reset, powered_down_o is 0, sdata_oe_o is 0, sdata_o is 0 and track_o is 1.
- R2: When chip-select falls while the part is awake, sdata_oe_o goes to 1 and the first frame bit (a zero) is driven.
- R3: The frame is 16 bits: four zeros, then the 12-bit sample captured when chip-select fell, MSB first. Frame bit k (k = 0..15) is on sdata_o after the k-th serial-clock falling edge of the frame.
- R4: After the 16th falling edge, sdata_oe_o returns to 0, and further falling edges in the same frame change nothing.
- R5: If the part is awake and chip-select rises after fewer than 2 falling edges, the part stays awake.
- R6: If the part is awake and chip-select rises after 2 to 9 falling edges, the part powers down and sdata_oe_o goes to 0.
- R7: If the part is awake and chip-select rises after 10 or more falling edges, the part stays awake and any transfer still running is aborted (sdata_oe_o goes to 0).
- R8: If the part is asleep, a frame released after fewer than 10 falling edges (including a burst of 8) leaves it asleep, and sdata_oe_o stays 0 for the whole frame.
- R9: If the part is asleep, a frame held for 10 or more falling edges wakes it. The next frame delivers valid data.
- R10: While the part is asleep, track_o is 0. In a frame started asleep, track_o goes to 1 at the first serial-clock edge of either polarity, and it returns to 0 if that frame leaves the part asleep.
- R11: Serial-clock edges while chip-select is high have no effect on the power mode or on the next frame's bit order.
- R12: Whenever sdata_oe_o is 0, sdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip-select, asynchronous to clk_i |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sample_i | input | DATA_W | Parallel conversion result |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Output enable for the serial data pad (0 means high impedance) |
| powered_down_o | output | 1 | 1 while the part is asleep |
| track_o | output | 1 | 1 while the sample-and-hold is tracking |

## Verification
The bench uses the default parameters: DATA_W=12, LEAD_W=4, PD_EDGE=2, KEEP_EDGE=10 and SYNC_STAGES=2. With these values the 16-bit frame, the 2- and 10-edge boundaries and the 8-clock wake-up rejection all fall within a short test. Random frame lengths from 0 to 20 falling edges, together with directed edges at 1, 2, 9, 10 and 16, cover every release window from both power states. They also cover over-length frames and serial-clock activity between frames.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  // next power state from the falling-edge count at chip-select release
  function automatic logic next_pd(input logic pd, input int cnt,
                                   input int pd_edge, input int keep_edge);
    if (pd) return (cnt >= keep_edge) ? 1'b0 : 1'b1;
    if (cnt >= pd_edge && cnt < keep_edge) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int                WIDTH   = 2,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= {(STAGES+1){RST_VAL[b]}};
      else         q <= {q[STAGES-1:0], d_i[b]};
    end
    assign rise_o[b] = q[STAGES-1] & ~q[STAGES];
    assign fall_o[b] = ~q[STAGES-1] & q[STAGES];
  end
endmodule

// File: rtl/adc_mode_fsm.sv
module adc_mode_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int FRAME     = 16,
  parameter int PD_EDGE   = 2,
  parameter int KEEP_EDGE = 10,
  localparam int CNT_W    = $clog2(FRAME + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  output logic             pd_o,
  output logic             track_o,
  output logic             shift_en_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             active_q, frame_pd_q, wake_trk_q, pd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  assign cnt_full = (cnt_q == CNT_W'(FRAME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      frame_pd_q <= 1'b0;
      wake_trk_q <= 1'b0;
      pd_q       <= 1'b0;
      cnt_q      <= '0;
    end else if (cs_fall_i) begin
      active_q   <= 1'b1;
      frame_pd_q <= pd_q;
      wake_trk_q <= 1'b0;
      cnt_q      <= '0;
    end else if (cs_rise_i && active_q) begin
      active_q   <= 1'b0;
      wake_trk_q <= 1'b0;
      pd_q       <= next_pd(pd_q, int'(cnt_q), PD_EDGE, KEEP_EDGE);
    end else if (active_q) begin
      if (sclk_fall_i && !cnt_full) cnt_q <= cnt_q + 1'b1;
      if ((sclk_fall_i || sclk_rise_i) && frame_pd_q) wake_trk_q <= 1'b1;
    end
  end

  assign pd_o       = pd_q;
  assign track_o    = !pd_q || wake_trk_q;
  assign shift_en_o = active_q && sclk_fall_i && !cnt_full && !cs_fall_i;
  assign last_o     = (cnt_q == CNT_W'(FRAME - 1));
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int DATA_W  = 12,
  parameter int LEAD_W  = 4,
  localparam int FRAME  = DATA_W + LEAD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              last_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              oe_o
);
  logic [FRAME-1:0] sreg_q;
  logic             oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      oe_q   <= 1'b0;
    end else if (load_i) begin
      sreg_q <= {{LEAD_W{1'b0}}, sample_i};
      oe_q   <= 1'b1;
    end else if (stop_i) begin
      oe_q   <= 1'b0;
    end else if (shift_i && oe_q) begin
      sreg_q <= {sreg_q[FRAME-2:0], 1'b0};
      if (last_i) oe_q <= 1'b0;
    end
  end

  assign oe_o    = oe_q;
  assign sdata_o = oe_q & sreg_q[FRAME-1];
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
  parameter int DATA_W      = 12,
  parameter int LEAD_W      = 4,
  parameter int PD_EDGE     = 2,
  parameter int KEEP_EDGE   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              powered_down_o,
  output logic              track_o
);
  localparam int FRAME = DATA_W + LEAD_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [1:0]       rise, fall;
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic             pd, shift_en, last;
  logic [CNT_W-1:0] cnt;

  // bit 1: chip-select (idles high), bit 0: serial clock
  adc_edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_n_i, sclk_i}), .rise_o(rise), .fall_o(fall)
  );
  assign cs_fall   = fall[1];
  assign cs_rise   = rise[1];
  assign sclk_fall = fall[0];
  assign sclk_rise = rise[0];

  adc_mode_fsm #(.FRAME(FRAME), .PD_EDGE(PD_EDGE), .KEEP_EDGE(KEEP_EDGE)) u_fsm (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .pd_o(pd), .track_o(track_o), .shift_en_o(shift_en),
    .last_o(last), .cnt_o(cnt)
  );

  adc_shift_out #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i(cs_fall && !pd), .shift_i(shift_en), .last_i(last),
    .stop_i(cs_rise), .sample_i(sample_i),
    .sdata_o(sdata_o), .oe_o(sdata_oe_o)
  );

  assign powered_down_o = pd;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
  parameter int FRAME = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic [CNT_W-1:0] cnt,
  input logic             sdata_o,
  input logic             sdata_oe_o,
  input logic             powered_down_o,
  input logic             track_o
);
  // R12
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);
  // R8
  no_drive_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdata_oe_o && powered_down_o));
  // R2
  oe_from_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(cs_fall));
  // R11
  mode_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(powered_down_o) |-> $past(cs_rise));
  // R10
  hold_only_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !track_o |-> powered_down_o);
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(FRAME));
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.FRAME(FRAME), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .cnt(cnt), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
  .powered_down_o(powered_down_o), .track_o(track_o)
);

// File: tb/adc_serial_ctrl_tb.sv
module adc_serial_ctrl_tb;
  localparam int DW = 12;
  localparam int FR = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_n_i = 1'b1;
  logic          sclk_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          sdata_o, sdata_oe_o, powered_down_o, track_o;

  int  checks = 0, failures = 0;
  bit  pd_m = 1'b0;

  always #2 clk_i = ~clk_i;

  adc_serial_ctrl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit frame_bit(input logic [DW-1:0] s, input int k);
    logic [FR-1:0] w;
    w = {4'b0000, s};
    return w[FR-1-k];
  endfunction

  function automatic bit model_pd(input bit pd, input int n);
    int c;
    c = (n > FR) ? FR : n;
    if (pd) return (c >= 10) ? 1'b0 : 1'b1;
    return (c >= 2 && c < 10);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // one frame with n falling edges; data checked bit by bit
  task automatic frame(input logic [DW-1:0] s, input int n);
    bit start_pd;
    start_pd = pd_m;
    sample_i = s;
    cs_n_i = 1'b0;
    wait_clk(8);
    sample_i = ~s;
    chk(start_pd ? "R8" : "R2", sdata_oe_o, !start_pd);
    if (!start_pd) chk("R3", sdata_o, 0);
    chk("R10", track_o, !start_pd);
    for (int k = 1; k <= n; k++) begin
      sclk_i = 1'b1;
      wait_clk(6);
      if (k == 1) chk("R10", track_o, 1);
      sclk_i = 1'b0;
      wait_clk(6);
      if (start_pd) chk("R8", sdata_oe_o, 0);
      else if (k < FR) begin
        chk("R3", sdata_oe_o, 1);
        chk("R3", sdata_o, frame_bit(s, k));
      end else begin
        chk("R4", sdata_oe_o, 0);
        chk("R12", sdata_o, 0);
      end
    end
    cs_n_i = 1'b1;
    wait_clk(8);
    pd_m = model_pd(start_pd, n);
    chk(start_pd ? "R9" : (n < 2 ? "R5" : (n < 10 ? "R6" : "R7")),
        powered_down_o, pd_m);
    chk("R7", sdata_oe_o, 0);
    chk("R10", track_o, !pd_m);
  endtask

  task automatic idle_clocks(input int n);
    for (int k = 0; k < n; k++) begin
      sclk_i = 1'b1; wait_clk(5);
      sclk_i = 1'b0; wait_clk(5);
    end
    chk("R11", powered_down_o, pd_m);
    chk("R12", sdata_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    chk("R1", powered_down_o, 0);
    chk("R1", sdata_oe_o, 0);
    chk("R1", sdata_o, 0);
    chk("R1", track_o, 1);

    frame(12'hA5C, 16);   // R3 full frame
    frame(12'h3F1, 20);   // R4 over-length
    frame(12'h001, 1);    // R5 glitch
    frame(12'hFFF, 9);    // R6 sleep
    frame(12'h123, 8);    // R8 burst of eight
    frame(12'h456, 2);    // R8
    idle_clocks(4);       // R11
    frame(12'h789, 10);   // R9 wake
    frame(12'hBCD, 16);   // R9 valid data next frame
    frame(12'h800, 2);    // R6 boundary
    frame(12'h7FF, 10);   // R9
    frame(12'h0F0, 12);   // R7 abort
    idle_clocks(3);       // R11
    frame(12'h555, 0);    // R5

    for (int i = 0; i < 60; i++) begin
      frame(12'($urandom), int'($urandom_range(0, 20)));
      if ($urandom_range(0, 3) == 0) idle_clocks(int'($urandom_range(1, 4)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule